// File: doc/BRIEF.md
# Signaling freeze and integration filter

This block sits between the per-channel capture stage and the presented outputs of a robbed-bit signaling extractor. Once per multiframe, on a one-cycle update tick, it receives a fresh four-bit signaling nibble for every channel. For each channel it decides whether that nibble may replace the value currently presented downstream.

Two rules govern that decision. The first is integration. Each channel keeps a candidate value and a saturating agreement count. The presented value changes only once the candidate has been seen on a required number of consecutive ticks. The two-bit mode input selects that number, or bypasses integration altogether.

The second rule is freezing. A slip event, or holding the active-low hold input low, blocks every update, and the old values recirculate unchanged. A freeze flag marks this condition. After a slip, and whenever the alarm input is high, the required agreement count is capped at two so that recovery is quick.

Top module: `sigf_filter`

## Requirements
- R1: While reset is asserted, every presented nibble reads 0 and the freeze flag reads 0.
- R2: With mode 00 (depth 1), every permitted tick copies each channel's input nibble to its output, which is visible the cycle after the tick.
- R3: With mode 01, 10 or 11, the required depth is 2, 3 or 4. A channel's output takes a new value on the permitted tick on which that value has been sampled on depth consecutive ticks, and not earlier.
- R4: A tick whose sample differs from the channel's candidate makes that sample the new candidate with an agreement count of 1. The count saturates at 4.
- R5: While hold_n is low, no tick changes any output. Agreement counting continues during this time.
- R6: A slip event blocks output updates on the tick in the same cycle and on the next mode+1 ticks after it (mode 00 gives 1, 11 gives 4). A new slip restarts this window.
- R7: The freeze flag goes high the cycle after a slip or a low hold_n. It stays high until the first permitted tick, and it is low the cycle after that tick.
- R8: While alarm is high, the required depth is min(mode+1, 2).
- R9: The first permitted tick after a slip also uses depth min(mode+1, 2). Later ticks use the full depth again.
- R10: Outputs change only in the cycle after an update tick.
- R11: Channels are filtered independently. Channel k's nibble occupies bits [4k+3:4k] of sig_in and sig_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_tick | input | 1 | One-cycle multiframe update strobe |
| sig_in | input | NCH*NIB | New signaling nibbles, channel k at bits [4k+3:4k] |
| slip_evt | input | 1 | One-cycle slip indication |
| hold_n | input | 1 | Active-low forced hold of all updates |
| alarm | input | 1 | Alarm level; caps the depth at 2 |
| mode | input | 2 | Integration depth and freeze length select |
| sig_out | output | NCH*NIB | Presented signaling nibbles |
| frz_flag | output | 1 | High while a freeze is in effect |

## Verification
The bench builds the filter with three channels and the default nibble width, counter cap and clamp depth. Three channels are few enough that one bus word can give each channel a different agreement history. With them, the bench shows one channel loading while its neighbour keeps restarting its count.

The default counter cap of four lets every mode's depth be reached. It also lets a hold that lasts longer than the depth drive a count into saturation. The clamp depth of two is the value that separates the clamped case from the unclamped case when the mode is 11.

// File: rtl/sigf_pkg.sv
package sigf_pkg;
  localparam int unsigned MODE_W = 2;
  typedef logic [MODE_W-1:0] sigf_mode_t;
endpackage

// File: rtl/sigf_freeze_ctl.sv
module sigf_freeze_ctl
  import sigf_pkg::*;
#(
  parameter int unsigned CW          = 3,
  parameter int unsigned CLAMP_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mf_tick,
  input  logic          slip_evt,
  input  logic          hold_n,
  input  logic          alarm,
  input  sigf_mode_t    mode,
  output logic          permit,
  output logic [CW-1:0] req_depth,
  output logic          frz_flag
);
  logic [CW-1:0] depth;
  logic [CW-1:0] frz_left_q, frz_left_d;
  logic          slip_pend_q, slip_pend_d;
  logic          flag_q, flag_d;
  logic          clamp_on;

  // depth and freeze length share the mode code: code + 1
  always_comb begin
    depth     = CW'(mode) + CW'(1);
    clamp_on  = alarm | slip_pend_q;
    req_depth = (clamp_on && (depth > CW'(CLAMP_DEPTH))) ? CW'(CLAMP_DEPTH) : depth;
    permit    = mf_tick & hold_n & ~slip_evt & (frz_left_q == '0);
  end

  always_comb begin
    frz_left_d = frz_left_q;
    if (slip_evt) begin
      frz_left_d = depth;
    end else if (mf_tick && (frz_left_q != '0)) begin
      frz_left_d = frz_left_q - CW'(1);
    end

    slip_pend_d = slip_pend_q;
    if (slip_evt) begin
      slip_pend_d = 1'b1;
    end else if (permit) begin
      slip_pend_d = 1'b0;
    end

    flag_d = flag_q;
    if (slip_evt || !hold_n) begin
      flag_d = 1'b1;
    end else if (permit) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_left_q  <= '0;
      slip_pend_q <= 1'b0;
      flag_q      <= 1'b0;
    end else begin
      frz_left_q  <= frz_left_d;
      slip_pend_q <= slip_pend_d;
      flag_q      <= flag_d;
    end
  end

  assign frz_flag = flag_q;
endmodule

// File: rtl/sigf_chan.sv
module sigf_chan #(
  parameter int unsigned NIB  = 4,
  parameter int unsigned CW   = 3,
  parameter int unsigned MAXD = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mf_tick,
  input  logic           permit,
  input  logic [CW-1:0]  req_depth,
  input  logic [NIB-1:0] samp_in,
  output logic [NIB-1:0] samp_out
);
  logic [NIB-1:0] cand_q, cand_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [NIB-1:0] out_q, out_d;
  logic           load;

  always_comb begin
    cand_d = cand_q;
    cnt_d  = cnt_q;
    if (mf_tick) begin
      if (samp_in != cand_q) begin
        cand_d = samp_in;
        cnt_d  = CW'(1);
      end else if (cnt_q < CW'(MAXD)) begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    load  = mf_tick & permit & (cnt_d >= req_depth);
    out_d = load ? cand_d : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      cnt_q  <= '0;
      out_q  <= '0;
    end else begin
      if (mf_tick) begin
        cand_q <= cand_d;
        cnt_q  <= cnt_d;
      end
      if (load) begin
        out_q <= out_d;
      end
    end
  end

  assign samp_out = out_q;
endmodule

// File: rtl/sigf_filter.sv
module sigf_filter
  import sigf_pkg::*;
#(
  parameter int unsigned NCH         = 24,
  parameter int unsigned NIB         = 4,
  parameter int unsigned MAXD        = 4,
  parameter int unsigned CLAMP_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mf_tick,
  input  logic [NCH*NIB-1:0] sig_in,
  input  logic               slip_evt,
  input  logic               hold_n,
  input  logic               alarm,
  input  logic [1:0]         mode,
  output logic [NCH*NIB-1:0] sig_out,
  output logic               frz_flag
);
  localparam int unsigned CW = $clog2(MAXD + 1);

  logic          permit;
  logic [CW-1:0] req_depth;

  sigf_freeze_ctl #(.CW(CW), .CLAMP_DEPTH(CLAMP_DEPTH)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mf_tick   (mf_tick),
    .slip_evt  (slip_evt),
    .hold_n    (hold_n),
    .alarm     (alarm),
    .mode      (sigf_mode_t'(mode)),
    .permit    (permit),
    .req_depth (req_depth),
    .frz_flag  (frz_flag)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    sigf_chan #(.NIB(NIB), .CW(CW), .MAXD(MAXD)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .mf_tick   (mf_tick),
      .permit    (permit),
      .req_depth (req_depth),
      .samp_in   (sig_in[k*NIB +: NIB]),
      .samp_out  (sig_out[k*NIB +: NIB])
    );
  end
endmodule

// File: rtl/sigf_filter_chk.sv
module sigf_filter_chk #(
  parameter int unsigned NCH = 24,
  parameter int unsigned NIB = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mf_tick,
  input logic [NCH*NIB-1:0] sig_in,
  input logic               slip_evt,
  input logic               hold_n,
  input logic [1:0]         mode,
  input logic [NCH*NIB-1:0] sig_out,
  input logic               frz_flag
);
  // R10
  quiet_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_tick |=> $stable(sig_out));

  // R5
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_tick && !hold_n) |=> $stable(sig_out));

  // R6
  slip_tick_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_tick && slip_evt) |=> $stable(sig_out));

  // R7
  flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_evt || !hold_n) |=> frz_flag);

  // R7
  flag_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_flag && !mf_tick) |=> frz_flag);

  // R2
  bypass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_tick && mode == 2'b00 && hold_n && !slip_evt && !frz_flag)
      |=> (sig_out == $past(sig_in)));
endmodule

bind sigf_filter sigf_filter_chk #(.NCH(NCH), .NIB(NIB)) u_sigf_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mf_tick  (mf_tick),
  .sig_in   (sig_in),
  .slip_evt (slip_evt),
  .hold_n   (hold_n),
  .mode     (mode),
  .sig_out  (sig_out),
  .frz_flag (frz_flag)
);

// File: tb/sigf_filter_bench.sv
`timescale 1ns/1ps
module sigf_filter_bench;
  localparam int NCH = 3;
  localparam int NIB = 4;
  localparam int W   = NCH * NIB;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mf_tick = 1'b0;
  logic [W-1:0] sig_in = '0;
  logic         slip_evt = 1'b0;
  logic         hold_n = 1'b1;
  logic         alarm = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] sig_out;
  logic         frz_flag;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string phase = "R1";

  always #5 clk = ~clk;

  sigf_filter #(.NCH(NCH), .NIB(NIB), .MAXD(4), .CLAMP_DEPTH(2)) u_sigf_filter (
    .clk(clk), .rst_n(rst_n), .mf_tick(mf_tick), .sig_in(sig_in),
    .slip_evt(slip_evt), .hold_n(hold_n), .alarm(alarm), .mode(mode),
    .sig_out(sig_out), .frz_flag(frz_flag)
  );

  // behavioural reference model
  int m_cand[NCH];
  int m_cnt[NCH];
  int m_out[NCH];
  int m_frz = 0;
  int m_flag = 0;
  int m_pend = 0;
  int d, req, s;
  bit perm;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_cand[c] = 0; m_cnt[c] = 0; m_out[c] = 0; end
      m_frz = 0; m_flag = 0; m_pend = 0;
    end else begin
      d    = int'(mode) + 1;
      perm = mf_tick && hold_n && !slip_evt && (m_frz == 0);
      req  = ((alarm || m_pend != 0) && d > 2) ? 2 : d;
      if (mf_tick) begin
        for (int c = 0; c < NCH; c++) begin
          s = int'((sig_in >> (NIB * c)) & 12'hF);
          if (s != m_cand[c]) begin m_cand[c] = s; m_cnt[c] = 1; end
          else if (m_cnt[c] < 4) m_cnt[c] = m_cnt[c] + 1;
          if (perm && m_cnt[c] >= req) m_out[c] = m_cand[c];
        end
      end
      if (slip_evt) m_frz = d;
      else if (mf_tick && m_frz > 0) m_frz = m_frz - 1;
      if (slip_evt) m_pend = 1; else if (perm) m_pend = 0;
      if (slip_evt || !hold_n) m_flag = 1; else if (perm) m_flag = 0;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int mism;
      mism = 0;
      for (int c = 0; c < NCH; c++)
        if (int'(sig_out[c*NIB +: NIB]) != m_out[c]) mism = 1;
      total++;
      if (mism != 0 || int'(frz_flag) != m_flag) begin
        bad++;
        $display("FAIL %s model: out=%h flag=%0d expected out=%h%h%h flag=%0d",
                 phase, sig_out, frz_flag, m_out[2][3:0], m_out[1][3:0], m_out[0][3:0], m_flag);
      end
    end
  end

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic mf(input logic [W-1:0] v);
    sig_in  = v;
    mf_tick = 1'b1;
    @(posedge clk); #2;
    mf_tick = 1'b0;
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic slip_pulse();
    slip_evt = 1'b1;
    @(posedge clk); #2;
    slip_evt = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got hung expected completion");
      summary();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1", sig_out, '0);
    check("R1", {{(W-1){1'b0}}, frz_flag}, '0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R2 bypass
    phase = "R2"; mode = 2'b00;
    mf(12'h3A9);
    check("R2", sig_out, 12'h3A9);
    mf(12'hF0E);
    mf(12'h555);
    check("R2", sig_out, 12'h555);

    // R3 depth 4
    phase = "R3"; mode = 2'b11;
    mf(12'hAAA); mf(12'hAAA); mf(12'hAAA);
    check("R3", sig_out, 12'h555);
    mf(12'hAAA);
    check("R3", sig_out, 12'hAAA);

    // R4 restart on change, depth 3
    phase = "R4"; mode = 2'b10;
    mf(12'hBBB); mf(12'hBBB); mf(12'hCCC); mf(12'hCCC);
    check("R4", sig_out, 12'hAAA);
    mf(12'hCCC);
    check("R4", sig_out, 12'hCCC);

    // R11 independent channels, depth 2
    phase = "R11"; mode = 2'b01;
    mf(12'hCDE);
    mf(12'hCDF);
    check("R11", sig_out, 12'hCDC);

    // R8 alarm clamp with mode 11
    phase = "R8"; mode = 2'b11; alarm = 1'b1;
    mf(12'h777);
    check("R8", sig_out, 12'hCDC);
    mf(12'h777);
    check("R8", sig_out, 12'h777);
    alarm = 1'b0;

    // R5 hold
    phase = "R5"; hold_n = 1'b0;
    mf(12'h111); mf(12'h111); mf(12'h111); mf(12'h111); mf(12'h111);
    check("R5", sig_out, 12'h777);
    check("R5", {{(W-1){1'b0}}, frz_flag}, 12'h001);

    // R7 flag persists until permitted tick
    phase = "R7"; hold_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R7", {{(W-1){1'b0}}, frz_flag}, 12'h001);
    mf(12'h111);
    check("R7", sig_out, 12'h111);
    check("R7", {{(W-1){1'b0}}, frz_flag}, 12'h000);

    // R6 slip freeze of 2 ticks with mode 01
    phase = "R6"; mode = 2'b01;
    slip_pulse();
    mf(12'h222); mf(12'h222);
    check("R6", sig_out, 12'h111);
    check("R6", {{(W-1){1'b0}}, frz_flag}, 12'h001);
    mf(12'h222);
    check("R6", sig_out, 12'h222);
    check("R6", {{(W-1){1'b0}}, frz_flag}, 12'h000);

    // R9 clamp on first permitted tick after slip, mode 11
    phase = "R9"; mode = 2'b11;
    slip_pulse();
    mf(12'h333); mf(12'h333); mf(12'h333); mf(12'h666);
    check("R9", sig_out, 12'h222);
    mf(12'h666);
    check("R9", sig_out, 12'h666);
    mf(12'h999); mf(12'h999);
    check("R9", sig_out, 12'h666);

    // R10 is checked by the per-clock model comparison throughout
    phase = "R10";
    repeat (4) @(posedge clk);
    #2;
    check("R10", sig_out, 12'h666);

    done = 1'b1;
    summary();
  end
endmodule